// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is a single 16-bit timer channel. It has a free-running up counter and two general-purpose slots, A and B. Software sets each slot either to compare mode or to capture mode. In compare mode the slot watches for the counter to equal its general register. On a match it raises its status flag and can drive an output pin low, drive it high or toggle it. In capture mode the slot samples the counter into its general register when a selected edge arrives on its capture pin.

Each slot also has a buffer register, enabled by its own control bit. The buffer moves data in the opposite direction in the two modes. In compare mode it is a shadow whose value is copied into the general register at every match, so software can stage the next compare value. In capture mode the general register's previous content is pushed into the buffer on each capture, which keeps the last two captured values. A small word/byte register port gives software access to everything. Each slot has an interrupt line gated by an enable bit.

Register map (word addresses on `cpu_addr`): 0 control, 1 status, 2 counter, 3 general A, 4 general B, 5 buffer A, 6 buffer B. Control byte 0 configures slot A and byte 1 configures slot B. Within each byte: bit 0 selects capture mode (0 = compare), bit 1 enables the buffer, bits 3:2 select the capture edge (00 none, 01 rising, 10 falling, 11 both), bits 5:4 select the pin action (00 none, 01 drive 0, 10 drive 1, 11 toggle), and bit 6 enables the interrupt. Status bit 0 is flag A and status bit 1 is flag B.

Top module: `cct_chan`

## Requirements
- R1: After reset all general and buffer registers read 0xFFFF, control and status read 0, both slots are in compare mode with pin action none, and both pins and both interrupt lines are low.
- R2: The counter rises by one every clock and wraps from 0xFFFF to 0x0000. A CPU write to address 2 loads it, and counting resumes from the loaded value.
- R3: In capture mode, the edge field picks which capture pin transitions trigger a capture: 01 rising only, 10 falling only, 11 both, 00 none. A transition that is not selected leaves the general register and the flag unchanged.
- R4: A capture pin passes through two synchronizer flops and an edge detector. A pin change set up before clock edge k loads the general register at edge k+2 with the counter value of the cycle just before that edge, and the slot's flag is set at the same edge.
- R5: In capture mode with the buffer enabled, each capture moves the old general register value into the buffer register at the same edge that loads the new counter value.
- R6: In compare mode, when the counter equals the general register, the slot's flag is set at the next edge. If the buffer is enabled, the buffer value is copied into the general register at that same edge.
- R7: On a compare match the slot's pin follows its action field: 00 unchanged, 01 driven 0, 10 driven 1, 11 inverted. Outside a match the pin holds its value.
- R8: Registers at addresses 0, 2 and 3 to 6 accept writes with byte enables: `cpu_be[0]` writes bits 7:0 and `cpu_be[1]` writes bits 15:8.
- R9: A flag clears only when status is written with that bit at 0 (with `cpu_be[0]` set) after a status read that saw the bit at 1. A write of 0 without that prior read leaves the flag set. If a hardware set falls in the same cycle as a clear, the flag stays set.
- R10: Each interrupt line is high exactly when its slot's flag is set and its interrupt enable bit is 1.
- R11: If a CPU write to a general or buffer register falls in the same cycle as a hardware transfer into that register, the hardware value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (arms flag clearing) |
| cpu_addr | input | 3 | Register word address |
| cpu_be | input | 2 | Byte enables for writes |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr`, combinational |
| cap_pin | input | 2 | Capture inputs, bit 0 slot A, bit 1 slot B |
| cmp_pin | output | 2 | Compare output pins, bit 0 slot A, bit 1 slot B |
| irq | output | 2 | Interrupt lines, bit 0 slot A, bit 1 slot B |

## Verification
The checker assumes the capture pins are low through reset, so the edge detector starts from a known level. It also assumes software does not change a slot's mode in the same cycle that slot's event fires. Its flag-hold property assumes status is cleared only through the documented write. The bench drives pins only at falling clock edges and never changes a capture pin and that slot's control in the same cycle. It reloads the counter to a small value before each compare setup, so a stale general register cannot produce an unplanned match while the next case is being set up.

// File: rtl/cct_pkg.sv
// Shared definitions for the capture/compare timer channel.
// Assumes a 16-bit register port with one-hot byte enables per byte.
package cct_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_GR0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_BR0  = 3'd5;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    // One slot's configuration, bit 0 is the capture-mode select.
    typedef struct packed {
        logic       ie;
        pin_act_e   act;
        logic [1:0] edg;
        logic       buf_en;
        logic       cap;
    } slot_cfg_t;

    localparam int CFG_W = $bits(slot_cfg_t);
endpackage

// File: rtl/cct_capsync.sv
// Capture input conditioning: two-flop synchronizer followed by an edge
// detector. Assumes the pin is low during reset. The event pulses for one
// cycle, on the cycle after the synchronized level changes.
module cct_capsync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edg,
    output logic       evt
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall;

    // Synchronize the pin and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Qualify the detected transitions with the selected edge set.
    always_comb begin
        rise = s2_q & ~prev_q;
        fall = ~s2_q & prev_q;
        evt  = (edg[0] & rise) | (edg[1] & fall);
    end
endmodule

// File: rtl/cct_slot.sv
// One capture/compare slot: general register, paired buffer register,
// status flag and compare pin. Hardware transfers take priority over CPU
// writes in the same cycle, and a hardware flag set beats a clear.
module cct_slot
    import cct_pkg::*;
#(
    parameter int W  = 16,
    parameter int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_cfg_t     cfg,
    input  logic [W-1:0]  cnt,
    input  logic          cap_evt,
    input  logic          gr_we,
    input  logic          br_we,
    input  logic [NB-1:0] be,
    input  logic [W-1:0]  wdata,
    input  logic          flag_clr,
    output logic [W-1:0]  gr,
    output logic [W-1:0]  br,
    output logic          flag,
    output logic          pin
);
    logic match, capture;

    function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                           input logic [W-1:0] new_v,
                                           input logic [NB-1:0] en);
        logic [W-1:0] r;
        r = old_v;
        for (int b = 0; b < NB; b++)
            if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

    // Decode the two hardware events of this slot.
    always_comb begin
        match   = !cfg.cap && (cnt == gr);
        capture = cfg.cap && cap_evt;
    end

    // General register: capture, then buffered compare reload, then CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gr <= '1;
        else if (capture)              gr <= cnt;
        else if (match && cfg.buf_en)  gr <= br;
        else if (gr_we)                gr <= merge(gr, wdata, be);
    end

    // Buffer register: receives the old general value on a buffered capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                      br <= '1;
        else if (capture && cfg.buf_en)  br <= gr;
        else if (br_we)                  br <= merge(br, wdata, be);
    end

    // Status flag: set on either event, set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (capture || match)  flag <= 1'b1;
        else if (flag_clr)          flag <= 1'b0;
    end

    // Compare output pin action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else if (match) begin
            case (cfg.act)
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                ACT_TOGGLE: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/cct_chan.sv
// Timer channel top: free-running counter, control and status registers,
// register read mux and two capture/compare slots. Assumes W is 16 so that
// each control byte holds one slot's configuration.
module cct_chan
    import cct_pkg::*;
#(
    parameter int W  = 16,
    parameter int NB = W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [NB-1:0]     cpu_be,
    input  logic [W-1:0]      cpu_wdata,
    output logic [W-1:0]      cpu_rdata,
    input  logic [1:0]        cap_pin,
    output logic [1:0]        cmp_pin,
    output logic [1:0]        irq
);
    localparam int NSLOT = 2;

    logic [W-1:0]              cnt_q;
    slot_cfg_t [NSLOT-1:0]     cfg_q;
    logic [NSLOT-1:0]          flag, arm_q, flag_clr, cap_evt;
    logic [NSLOT-1:0][W-1:0]   gr_v, br_v;

    function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                           input logic [W-1:0] new_v,
                                           input logic [NB-1:0] en);
        logic [W-1:0] r;
        r = old_v;
        for (int b = 0; b < NB; b++)
            if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

    // Free-running counter with CPU load.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (cpu_we && cpu_addr == A_CNT)     cnt_q <= merge(cnt_q, cpu_wdata, cpu_be);
        else                                      cnt_q <= cnt_q + 1'b1;
    end

    // Control register, one byte per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (cpu_we && cpu_addr == A_CTRL) begin
            for (int s = 0; s < NSLOT; s++)
                if (cpu_be[s]) cfg_q[s] <= slot_cfg_t'(cpu_wdata[s*8 +: CFG_W]);
        end
    end

    // Flag clear request: status write of 0 after an arming read.
    always_comb begin
        for (int s = 0; s < NSLOT; s++)
            flag_clr[s] = cpu_we && cpu_addr == A_STAT && cpu_be[0]
                          && !cpu_wdata[s] && arm_q[s];
    end

    // Arm a flag for clearing when software reads it as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (flag_clr[s])                                   arm_q[s] <= 1'b0;
                else if (cpu_re && cpu_addr == A_STAT && flag[s])  arm_q[s] <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        cct_capsync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[i]),
            .edg   (cfg_q[i].edg),
            .evt   (cap_evt[i])
        );
        cct_slot #(.W(W), .NB(NB)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg_q[i]),
            .cnt      (cnt_q),
            .cap_evt  (cap_evt[i]),
            .gr_we    (cpu_we && cpu_addr == A_GR0 + ADDR_W'(i)),
            .br_we    (cpu_we && cpu_addr == A_BR0 + ADDR_W'(i)),
            .be       (cpu_be),
            .wdata    (cpu_wdata),
            .flag_clr (flag_clr[i]),
            .gr       (gr_v[i]),
            .br       (br_v[i]),
            .flag     (flag[i]),
            .pin      (cmp_pin[i])
        );
        assign irq[i] = flag[i] & cfg_q[i].ie;
    end

    // Register read mux.
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            A_CTRL:       for (int s = 0; s < NSLOT; s++) cpu_rdata[s*8 +: CFG_W] = cfg_q[s];
            A_STAT:       cpu_rdata[NSLOT-1:0] = flag;
            A_CNT:        cpu_rdata = cnt_q;
            A_GR0:        cpu_rdata = gr_v[0];
            A_GR0 + 3'd1: cpu_rdata = gr_v[1];
            A_BR0:        cpu_rdata = br_v[0];
            A_BR0 + 3'd1: cpu_rdata = br_v[1];
            default:      cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_chan_chk.sv
// Property checker for the timer channel, bound into every cct_chan.
// Assumes capture pins are low during reset.
module cct_chan_chk
    import cct_pkg::*;
#(
    parameter int W  = 16,
    parameter int NB = W / 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_we,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic [NB-1:0]         cpu_be,
    input logic [W-1:0]          cpu_wdata,
    input logic [W-1:0]          cnt_q,
    input slot_cfg_t [1:0]       cfg_q,
    input logic [1:0]            flag,
    input logic [1:0]            cap_evt,
    input logic [1:0][W-1:0]     gr_v,
    input logic [1:0][W-1:0]     br_v,
    input logic [1:0]            cmp_pin
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == A_CNT) |=> cnt_q == $past(cnt_q) + 1'b1);

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R4 R11
        cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[i] && cfg_q[i].cap) |=> (gr_v[i] == $past(cnt_q)) && flag[i]);

        // R5 R11
        cap_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[i] && cfg_q[i].cap && cfg_q[i].buf_en) |=> br_v[i] == $past(gr_v[i]));

        // R6
        cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_q[i].cap && cfg_q[i].buf_en && cnt_q == gr_v[i])
            |=> (gr_v[i] == $past(br_v[i])) && flag[i]);

        // R7
        pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(!cfg_q[i].cap && cnt_q == gr_v[i]) |=> $stable(cmp_pin[i]));

        // R9
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !(cpu_we && cpu_addr == A_STAT && cpu_be[0] && !cpu_wdata[i]))
            |=> flag[i]);
    end
endmodule

bind cct_chan cct_chan_chk #(.W(W), .NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_be    (cpu_be),
    .cpu_wdata (cpu_wdata),
    .cnt_q     (cnt_q),
    .cfg_q     (cfg_q),
    .flag      (flag),
    .cap_evt   (cap_evt),
    .gr_v      (gr_v),
    .br_v      (br_v),
    .cmp_pin   (cmp_pin)
);

// File: tb/sim_cct_chan.sv
`timescale 1ns/1ps
module sim_cct_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0, cpu_re = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [1:0]  cpu_be = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [1:0]  cap_pin = '0;
    logic [1:0]  cmp_pin, irq;

    int n_chk = 0, n_fail = 0;
    logic [15:0] d, exp_gr, exp_br, base;

    localparam logic [2:0] CTRL = 0, STAT = 1, CNT = 2, GRA = 3, GRB = 4, BRA = 5, BRB = 6;

    cct_chan u0 (.*);

    always #2 clk = ~clk;

    // Slot configuration byte, layout as listed in the brief.
    function automatic logic [7:0] cfgb(bit cap, bit bf, logic [1:0] edg, logic [1:0] act, bit ie);
        return {1'b0, ie, act, edg, bf, cap};
    endfunction
    function automatic logic [15:0] exp_cap(logic [15:0] b, int n);
        return b + 16'(n) + 16'd2;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [1:0] be, logic [15:0] v);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_be = be; cpu_wdata = v;
        @(posedge clk); #1;
        cpu_we = 1'b0; cpu_be = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        cpu_re = 1'b1; cpu_addr = a;
        #0.5 v = cpu_rdata;
        @(posedge clk); #1;
        cpu_re = 1'b0;
    endtask

    task automatic clr_flags();
        logic [15:0] t;
        rd(STAT, t);
        wr(STAT, 2'b01, 16'h0000);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(GRA, d);  chk("R1 GRA", d, 16'hFFFF);
        rd(GRB, d);  chk("R1 GRB", d, 16'hFFFF);
        rd(BRA, d);  chk("R1 BRA", d, 16'hFFFF);
        rd(BRB, d);  chk("R1 BRB", d, 16'hFFFF);
        rd(CTRL, d); chk("R1 CTRL", d, 16'h0000);
        rd(STAT, d); chk("R1 STAT", d, 16'h0000);
        chk("R1 pins", {14'd0, cmp_pin}, 16'd0);
        chk("R1 irq", {14'd0, irq}, 16'd0);

        // R2 load, count and wrap
        wr(CNT, 2'b11, 16'h0100);
        rd(CNT, d); chk("R2 load", d, 16'h0100);
        wr(CNT, 2'b11, 16'hFFFE);
        repeat (3) @(negedge clk);
        rd(CNT, d); chk("R2 wrap", d, 16'h0001);

        // R8 byte writes
        wr(GRB, 2'b11, 16'h1234);
        wr(GRB, 2'b10, 16'hAB00);
        rd(GRB, d); chk("R8 high byte", d, 16'hAB34);
        wr(GRB, 2'b01, 16'h00CD);
        rd(GRB, d); chk("R8 low byte", d, 16'hABCD);

        // R4 rising capture, no buffer
        wr(CTRL, 2'b11, {8'h00, cfgb(1, 0, 2'b01, 2'b00, 0)});
        base = 16'h2000;
        wr(CNT, 2'b11, base);
        @(negedge clk); repeat (3) @(negedge clk);
        cap_pin[0] = 1'b1;
        repeat (6) @(negedge clk);
        rd(GRA, d);  chk("R4 capture value", d, exp_cap(base, 3));
        rd(STAT, d); chk("R4 flag", d & 16'h1, 16'h1);
        rd(BRA, d);  chk("R4 no buffer move", d, 16'hFFFF);
        exp_gr = exp_cap(base, 3);

        // R3 falling edge not selected, then none selected
        clr_flags();
        cap_pin[0] = 1'b0;
        repeat (8) @(negedge clk);
        rd(GRA, d);  chk("R3 fall ignored GR", d, exp_gr);
        rd(STAT, d); chk("R3 fall ignored flag", d & 16'h1, 16'h0);
        wr(CTRL, 2'b11, {8'h00, cfgb(1, 0, 2'b00, 2'b00, 0)});
        cap_pin[0] = 1'b1;
        repeat (8) @(negedge clk);
        rd(GRA, d);  chk("R3 none ignored GR", d, exp_gr);
        rd(STAT, d); chk("R3 none ignored flag", d & 16'h1, 16'h0);

        // R5 buffered capture on slot B with both edges
        wr(CTRL, 2'b11, {cfgb(1, 1, 2'b11, 2'b00, 0), 8'h00});
        base = 16'h3000;
        wr(CNT, 2'b11, base);
        @(negedge clk);
        cap_pin[1] = 1'b1;
        repeat (6) @(negedge clk);
        rd(GRB, d); chk("R5 first capture", d, exp_cap(base, 0));
        rd(BRB, d); chk("R5 old GR to BR", d, 16'hABCD);
        wr(CNT, 2'b11, base);
        @(negedge clk); repeat (5) @(negedge clk);
        cap_pin[1] = 1'b0;
        repeat (6) @(negedge clk);
        rd(GRB, d); chk("R5 second capture (fall)", d, exp_cap(base, 5));
        rd(BRB, d); chk("R5 BR holds first", d, exp_cap(base, 0));

        // R11 capture wins over same-cycle CPU write
        wr(CTRL, 2'b11, {8'h00, cfgb(1, 0, 2'b10, 2'b00, 0)});
        base = 16'h4000;
        wr(CNT, 2'b11, base);
        @(negedge clk);
        cap_pin[0] = 1'b0;
        @(negedge clk);
        wr(GRA, 2'b11, 16'h5555);
        repeat (3) @(negedge clk);
        rd(GRA, d); chk("R11 hardware priority", d, exp_cap(base, 0));

        // R6 R7 buffered compare with each pin action
        wr(CTRL, 2'b11, 16'h0000);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] act;
            logic       exp_pin;
            act = (k == 0) ? 2'b10 : (k == 1) ? 2'b01 : (k == 2) ? 2'b11 : 2'b00;
            exp_pin = (k == 1) ? 1'b0 : 1'b1;
            clr_flags();
            wr(CNT, 2'b11, 16'h0000);
            base = 16'h1000 + 16'(k) * 16'h1000;
            wr(GRA, 2'b11, base + 16'd5);
            wr(BRA, 2'b11, 16'hEE00 + 16'(k));
            wr(CTRL, 2'b11, {8'h00, cfgb(0, 1, 2'b00, act, 0)});
            wr(CNT, 2'b11, base);
            repeat (20) @(negedge clk);
            chk("R7 pin action", {15'd0, cmp_pin[0]}, {15'd0, exp_pin});
            rd(GRA, d);  chk("R6 buffer reload", d, 16'hEE00 + 16'(k));
            rd(STAT, d); chk("R6 match flag", d & 16'h1, 16'h1);
        end

        // R10 interrupt gating (flag A is set here)
        chk("R10 irq disabled", {15'd0, irq[0]}, 16'd0);
        wr(CTRL, 2'b01, {8'h00, cfgb(0, 0, 2'b00, 2'b00, 1)});
        @(negedge clk);
        chk("R10 irq enabled", {15'd0, irq[0]}, 16'd1);

        // R9 clear protocol (flag A armed by the last read, clear it and re-set)
        clr_flags();
        wr(CNT, 2'b11, 16'h0000);
        wr(GRA, 2'b11, 16'h0100);
        wr(CNT, 2'b11, 16'h00F0);
        repeat (30) @(negedge clk);
        wr(STAT, 2'b01, 16'h0000);
        @(negedge clk);
        chk("R9 unarmed clear ignored", {15'd0, irq[0]}, 16'd1);
        rd(STAT, d); chk("R9 flag still set", d & 16'h1, 16'h1);
        wr(STAT, 2'b01, 16'h0000);
        rd(STAT, d); chk("R9 armed clear", d & 16'h1, 16'h0);
        chk("R10 irq low after clear", {15'd0, irq[0]}, 16'd0);

        // R3 R4 R5 randomized captures on slot A
        void'($urandom(32'd1234));
        wr(CTRL, 2'b11, 16'h0000);
        rd(GRA, d); exp_gr = d;
        rd(BRA, d); exp_br = d;
        for (int it = 0; it < 12; it++) begin
            bit         bf;
            int         n;
            logic [1:0] edg;
            bf   = 1'($urandom_range(0, 1));
            n    = $urandom_range(0, 7);
            base = 16'h1000 + 16'($urandom_range(0, 16'h6000));
            edg  = ($urandom_range(0, 1) == 1) ? 2'b11 : (cap_pin[0] ? 2'b10 : 2'b01);
            clr_flags();
            wr(CTRL, 2'b11, {8'h00, cfgb(1, bf, edg, 2'b00, 0)});
            wr(CNT, 2'b11, base);
            @(negedge clk); repeat (n) @(negedge clk);
            cap_pin[0] = ~cap_pin[0];
            repeat (6) @(negedge clk);
            if (bf) exp_br = exp_gr;
            exp_gr = exp_cap(base, n);
            rd(GRA, d);  chk("R4 random capture", d, exp_gr);
            rd(BRA, d);  chk("R5 random buffer", d, exp_br);
            rd(STAT, d); chk("R3 random flag", d & 16'h1, 16'h1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule